// File: doc/BRIEF.md
# Latching Heartbeat Watchdog with RF Kill

This block supervises a periodic heartbeat pulse from a host that controls a transmitter. Each heartbeat restarts an elapsed-time count. When the count reaches the timeout (`CLK_FREQ * TIMEOUT_SEC` clocks), the block raises `triggered` and asserts `rf_kill`. `rf_kill` is the transmitter shutdown signal, and it stays asserted after the host comes back. Only an operator `force_reset`, dropping `enable`, or a chip reset releases it. The design is fail-safe: a lost host never results in the transmitter being switched back on automatically.

Before the timeout, `warning` goes high once the count reaches `CLK_FREQ * WARNING_SEC` clocks. `time_remaining` gives the whole seconds left before the trip, rounded up. The count is kept as a sub-second prescaler plus a seconds-left register. This means the seconds output and both thresholds come from small comparisons, with no division.

Top module: `hb_failsafe_wdog`

## Requirements
- R1: The reset is synchronous and active low. After a clock edge with `rst_n` low, the count is zero, `warning`, `triggered` and `rf_kill` are 0, and `time_remaining` equals TIMEOUT_SEC.
- R2: A clock edge with `heartbeat` high (enable high, no force_reset) sets the count to zero. After that edge, `warning` and `triggered` are 0 and `time_remaining` equals TIMEOUT_SEC.
- R3: After a clock edge with `enable` low, all state is cleared, including the RF-kill latch. The outputs show the same values as after reset.
- R4: When none of the clearing inputs are active, the count rises by exactly one per clock. It saturates at TIMEOUT_CYCLES, and `triggered` stays high while the count is saturated.
- R5: `triggered` is 1 exactly when the count is at least TIMEOUT_CYCLES. It rises TIMEOUT_CYCLES clocks after the last clearing edge.
- R6: `warning` is 1 exactly when the count is at least WARNING_CYCLES (= CLK_FREQ*WARNING_SEC, 0 < WARNING_SEC < TIMEOUT_SEC). Therefore `triggered` implies `warning`.
- R7: `time_remaining` equals ceil((TIMEOUT_CYCLES - count) / CLK_FREQ). It is TIMEOUT_SEC at count 0 and 0 when triggered, and it never increases while counting.
- R8: `rf_kill` is high whenever `triggered` is high. It stays high after a later heartbeat, until an edge with `force_reset` high, `enable` low or `rst_n` low.
- R9: After an edge with `force_reset` high, all state is cleared. `force_reset` takes priority over a `heartbeat` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Low clears all state and outputs |
| heartbeat | input | 1 | Host alive pulse; restarts the count |
| force_reset | input | 1 | Operator reset; clears everything, including the RF-kill latch |
| warning | output | 1 | Count has reached the warning threshold |
| triggered | output | 1 | Count has reached the timeout |
| rf_kill | output | 1 | Latched transmitter shutdown |
| time_remaining | output | $clog2(TIMEOUT_SEC+1) | Whole seconds left before the trip, rounded up |

## Verification
Every input acts at the clock edge where it is sampled. The count state changes at that edge, and `warning`, `triggered`, `time_remaining` and `rf_kill` are combinational from the count and the latch, so every output is due in the same cycle, right after that edge. The bench changes inputs on the falling edge and applies one edge of its arithmetic reference model per rising edge. It compares all four outputs at the next falling edge. The RF-kill latch sets on the edge after `triggered` is first seen, but `rf_kill` also follows `triggered` directly, so no lag shows at the port.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Action applied to the watchdog state at the next clock edge.
    typedef enum logic [1:0] {
        ACT_CLEAR   = 2'd0,
        ACT_RESTART = 2'd1,
        ACT_COUNT   = 2'd2
    } wd_act_e;

    // Priority: reset, then enable low, then force_reset (all clear),
    // then heartbeat (restart only), otherwise count.
    function automatic wd_act_e pick_act(input logic rst_n,
                                         input logic enable,
                                         input logic heartbeat,
                                         input logic force_reset);
        if (!rst_n || !enable || force_reset)
            return ACT_CLEAR;
        if (heartbeat)
            return ACT_RESTART;
        return ACT_COUNT;
    endfunction

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter
    import wdog_pkg::*;
#(
    parameter int unsigned CLK_FREQ    = 125_000_000,
    parameter int unsigned TIMEOUT_SEC = 5,
    localparam int unsigned SUB_W      = width_of(CLK_FREQ),
    localparam int unsigned SEC_W      = $clog2(TIMEOUT_SEC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wd_act_e          act,
    output logic [SEC_W-1:0] sec_left
);

    localparam logic [SUB_W-1:0] SUB_MAX  = SUB_W'(CLK_FREQ - 1);
    localparam logic [SEC_W-1:0] SEC_FULL = SEC_W'(TIMEOUT_SEC);

    logic [SUB_W-1:0] sub_q;
    logic [SEC_W-1:0] sec_q;

    always_ff @(posedge clk) begin
        case (act)
            ACT_CLEAR, ACT_RESTART: begin
                sub_q <= '0;
                sec_q <= SEC_FULL;
            end
            default: begin
                if (sec_q != '0) begin
                    if (sub_q == SUB_MAX) begin
                        sub_q <= '0;
                        sec_q <= sec_q - 1'b1;
                    end else begin
                        sub_q <= sub_q + 1'b1;
                    end
                end
            end
        endcase
    end

    assign sec_left = sec_q;

    // Once the timeout is reached, counting holds the state fixed.
    assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act) == ACT_COUNT && $past(sec_q) == '0)
            |-> (sec_q == '0 && $stable(sub_q)));

    // While counting, seconds left never goes up.
    assert_sec_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act) == ACT_COUNT) |-> (sec_q <= $past(sec_q)));

endmodule

// File: rtl/wdog_status.sv
module wdog_status
    import wdog_pkg::*;
#(
    parameter int unsigned TIMEOUT_SEC = 5,
    parameter int unsigned WARNING_SEC = 3,
    localparam int unsigned SEC_W      = $clog2(TIMEOUT_SEC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wd_act_e          act,
    input  logic [SEC_W-1:0] sec_left,
    output logic             warning,
    output logic             triggered,
    output logic             rf_kill
);

    // count >= WARNING_SEC*CLK_FREQ  <=>  seconds left <= TIMEOUT_SEC-WARNING_SEC
    localparam logic [SEC_W-1:0] WARN_LEVEL = SEC_W'(TIMEOUT_SEC - WARNING_SEC);

    logic kill_q;

    always_comb begin
        triggered = (sec_left == '0);
        warning   = (sec_left <= WARN_LEVEL);
        rf_kill   = kill_q | triggered;
    end

    always_ff @(posedge clk) begin
        if (act == ACT_CLEAR)
            kill_q <= 1'b0;
        else if (triggered)
            kill_q <= 1'b1;
    end

    // A heartbeat alone never releases the kill.
    assert_kill_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rf_kill) && $past(act) != ACT_CLEAR) |-> rf_kill);

endmodule

// File: rtl/hb_failsafe_wdog.sv
module hb_failsafe_wdog
    import wdog_pkg::*;
#(
    parameter int unsigned CLK_FREQ    = 125_000_000,
    parameter int unsigned TIMEOUT_SEC = 5,
    parameter int unsigned WARNING_SEC = 3,
    localparam int unsigned SEC_W      = $clog2(TIMEOUT_SEC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             heartbeat,
    input  logic             force_reset,
    output logic             warning,
    output logic             triggered,
    output logic             rf_kill,
    output logic [SEC_W-1:0] time_remaining
);

    localparam logic [SEC_W-1:0] SEC_FULL = SEC_W'(TIMEOUT_SEC);

    wd_act_e          act;
    logic [SEC_W-1:0] sec_left;

    assign act = pick_act(rst_n, enable, heartbeat, force_reset);

    wdog_tick_counter #(
        .CLK_FREQ   (CLK_FREQ),
        .TIMEOUT_SEC(TIMEOUT_SEC)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .sec_left(sec_left)
    );

    wdog_status #(
        .TIMEOUT_SEC(TIMEOUT_SEC),
        .WARNING_SEC(WARNING_SEC)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .sec_left (sec_left),
        .warning  (warning),
        .triggered(triggered),
        .rf_kill  (rf_kill)
    );

    assign time_remaining = sec_left;

    assert_hb_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(enable) && $past(heartbeat) && !$past(force_reset))
            |-> (!warning && !triggered && time_remaining == SEC_FULL));

    assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(enable))
            |-> (!warning && !triggered && !rf_kill && time_remaining == SEC_FULL));

    assert_force_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(force_reset))
            |-> (!warning && !triggered && !rf_kill && time_remaining == SEC_FULL));

    assert_trip_kills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        triggered |-> (rf_kill && warning && time_remaining == '0));

endmodule

// File: tb/sim_hb_failsafe_wdog.sv
`timescale 1ns/1ps
module sim_hb_failsafe_wdog;

    localparam int F  = 4;
    localparam int TS = 5;
    localparam int WS = 3;
    localparam int TC = F * TS;
    localparam int WC = F * WS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       heartbeat = 1'b0;
    logic       force_reset = 1'b0;
    logic       warning, triggered, rf_kill;
    logic [2:0] time_remaining;

    int errors = 0;
    int checks = 0;
    int m_cnt = 0;
    bit m_latch = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hb_failsafe_wdog #(
        .CLK_FREQ(F), .TIMEOUT_SEC(TS), .WARNING_SEC(WS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .heartbeat(heartbeat),
        .force_reset(force_reset), .warning(warning), .triggered(triggered),
        .rf_kill(rf_kill), .time_remaining(time_remaining)
    );

    task automatic chk(input string tag, input string sig, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (model count=%0d)",
                     tag, sig, act, exp, m_cnt);
        end
    endtask

    // One clock: drive at falling edge, apply model at rising edge, check at next falling edge.
    task automatic cyc(input bit rn, input bit en, input bit hb, input bit fr, input string tag);
        rst_n = rn; enable = en; heartbeat = hb; force_reset = fr;
        @(posedge clk);
        if (!rn || !en || fr) begin
            m_cnt = 0; m_latch = 1'b0;
        end else begin
            if (m_cnt >= TC) m_latch = 1'b1;
            if (hb) m_cnt = 0;
            else if (m_cnt < TC) m_cnt++;
        end
        @(negedge clk);
        chk({tag, "/R5"}, "triggered", int'(triggered), int'(m_cnt >= TC));
        chk({tag, "/R6"}, "warning", int'(warning), int'(m_cnt >= WC));
        chk({tag, "/R7"}, "time_remaining", int'(time_remaining), (TC - m_cnt + F - 1) / F);
        chk({tag, "/R8"}, "rf_kill", int'(rf_kill), int'(m_latch || (m_cnt >= TC)));
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cyc(0, 0, 0, 0, "R1");
        cyc(0, 1, 1, 1, "R1");
        // R4/R5/R6/R7: free count from zero past saturation
        for (int i = 0; i < TC + 4; i++) cyc(1, 1, 0, 0, "R4");
        // R8: heartbeat after trip keeps kill; R2 restart
        cyc(1, 1, 1, 0, "R2");
        for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, "R8");
        // R9: force_reset wins over heartbeat
        cyc(1, 1, 1, 1, "R9");
        // R2: sweep heartbeat gaps across every count value
        for (int g = 0; g <= TC + 1; g++) begin
            for (int k = 0; k < g; k++) cyc(1, 1, 0, 0, "R2");
            cyc(1, 1, 1, 0, "R2");
        end
        // R3: enable low releases kill
        for (int i = 0; i < TC + 2; i++) cyc(1, 1, 0, 0, "R5");
        cyc(1, 0, 0, 0, "R3");
        cyc(1, 0, 1, 0, "R3");
        for (int i = 0; i < WC + 1; i++) cyc(1, 1, 0, 0, "R6");
        // R1: reset while tripped
        for (int i = 0; i < TC; i++) cyc(1, 1, 0, 0, "R7");
        cyc(0, 1, 0, 0, "R1");
        // R9: force_reset alone after trip, then recount
        for (int i = 0; i < TC + 1; i++) cyc(1, 1, 0, 0, "R5");
        cyc(1, 1, 0, 1, "R9");
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, "R4");
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule